// File: doc/BRIEF.md
# Three-Wide Floating-Point Issue Scheduler

This block is an out-of-order scheduling window for floating-point and packed-integer micro-operations. Each cycle a front end may offer a group of up to three new operations. Each carries two source tags with their ready flags, an operation class and a destination tag. Up to three result tags come back each cycle on a broadcast bus. Any waiting source that matches one of them becomes ready.

Every cycle the scheduler picks at most one eligible operation for each of three logical pipes: add, multiply and store. Among the candidates for a pipe, it always takes the oldest. Operations of some classes are bound to one pipe. Packed-integer operations that are not multiplies may take either the add or the multiply pipe. The chosen operations leave through registered per-pipe outputs that carry the destination tag. Their entries are released at the same clock edge.

Top module: `fp_issue_sched`

## Requirements
- R1: After a synchronous reset the window is empty, all three pipe valid outputs are low, and `full` is low.
- R2: The window holds 36 entries, and up to three operations, one per write lane, are accepted in a cycle. Filling all 36 entries with blocked operations is accepted without `full` rising.
- R3: `full` rises, combinationally in the same cycle, when the number of valid write lanes exceeds the number of free entries. In that cycle none of the offered operations is written.
- R4: An entry is eligible only when both of its source ready flags are set. An entry with a missing source is never issued.
- R5: A broadcast tag (lane valid in `wb_vld`) sets every matching source ready flag at the clock edge. This includes operations written in the same cycle. The entry's issue then appears on the pipe outputs one edge later.
- R6: Class codes on `wr_cls` steer operations to pipes:
  - 0 (floating add) uses the add pipe only.
  - 1 (floating multiply) uses the multiply pipe only.
  - 2 (store) uses the store pipe only.
  - 3 (packed-integer non-multiply) may use the add or the multiply pipe.
  - 4 (packed-integer multiply) uses the multiply pipe only.
- R7: Each pipe issues at most one operation per cycle, and no entry issues to two pipes. Among a pipe's candidates the oldest wins. Age follows write order: an earlier cycle is older, and within one cycle a lower write lane is older.
- R8: The add pipe takes the oldest eligible class 0 or 3 entry. The multiply pipe takes the oldest eligible class 1, 3 or 4 entry other than the one the add pipe took.
- R9: An issued entry is freed at the issue edge. Its slot cannot be reused by a write in that same cycle, but it can be reused in the next cycle.
- R10: Pipe outputs are registered. A pipe valid output is high for one cycle per issued operation, with that operation's destination tag on the matching `*_dst` output. An operation written ready is issued on the outputs one edge after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_vld | input | 3 | Per-lane write valid |
| wr_cls | input | 3x3 | Per-lane operation class code |
| wr_src_a | input | 3x6 | Per-lane first source tag |
| wr_rdy_a | input | 3 | Per-lane first source already ready |
| wr_src_b | input | 3x6 | Per-lane second source tag |
| wr_rdy_b | input | 3 | Per-lane second source already ready |
| wr_dst | input | 3x6 | Per-lane destination tag |
| wb_vld | input | 3 | Per-lane result broadcast valid |
| wb_tag | input | 3x6 | Per-lane broadcast result tag |
| full | output | 1 | Offered group does not fit; nothing written |
| add_vld | output | 1 | Add pipe issue valid |
| add_dst | output | 6 | Destination tag issued to the add pipe |
| mul_vld | output | 1 | Multiply pipe issue valid |
| mul_dst | output | 6 | Destination tag issued to the multiply pipe |
| st_vld | output | 1 | Store pipe issue valid |
| st_dst | output | 6 | Destination tag issued to the store pipe |

## Verification
The bench first applies directed patterns:
- One operation of each fixed class, which separates the three steering paths.
- Packed-integer groups, which show whether the second pick skips the entry the add pipe already took.
- Same-class bursts over two cycles, which separate cycle order from lane order.
- Blocked entries woken by a later broadcast or by a same-cycle broadcast.
- A fill to exactly 36 entries followed by a one-entry overflow and a reuse in the next cycle.

Random mixes of classes, ready flags and broadcasts then run against a cycle model of the window. This exercises contention for the add pipe and the multiply pipe, and window pressure, in combinations the directed cases do not reach.

// File: rtl/fp_issue_pkg.sv
package fp_issue_pkg;
  localparam int CLS_W = 3;

  typedef enum logic [CLS_W-1:0] {
    OC_FADD  = 3'd0,
    OC_FMUL  = 3'd1,
    OC_STORE = 3'd2,
    OC_PADD  = 3'd3,
    OC_PMUL  = 3'd4
  } op_cls_e;
endpackage

// File: rtl/fp_issue_alloc.sv
// Hands out the lowest free slots, in lane order, to the valid write lanes.
// full is raised when any valid lane finds no slot.
module fp_issue_alloc #(
  parameter int DEPTH = 36,
  parameter int LANES = 3
) (
  input  logic [DEPTH-1:0]            free_mask,
  input  logic [LANES-1:0]            req,
  output logic [LANES-1:0][DEPTH-1:0] slot,
  output logic                        full
);
  logic [DEPTH-1:0] avail;

  always_comb begin
    avail = free_mask;
    full  = 1'b0;
    for (int l = 0; l < LANES; l++) begin
      slot[l] = '0;
      if (req[l]) begin
        slot[l] = avail & (~avail + 1'b1);
        avail   = avail & ~slot[l];
        if (slot[l] == '0) full = 1'b1;
      end
    end
  end
endmodule

// File: rtl/fp_issue_pick.sv
// Oldest-first select: blk[i][j] set means entry j is older than entry i.
module fp_issue_pick #(
  parameter int DEPTH = 36
) (
  input  logic [DEPTH-1:0]            cand,
  input  logic [DEPTH-1:0][DEPTH-1:0] blk,
  output logic [DEPTH-1:0]            sel
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_sel
    assign sel[i] = cand[i] & ~|(cand & blk[i]);
  end
endmodule

// File: rtl/fp_issue_sched.sv
module fp_issue_sched
  import fp_issue_pkg::*;
#(
  parameter int DEPTH = 36,
  parameter int LANES = 3,
  parameter int TAG_W = 6
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [LANES-1:0]            wr_vld,
  input  logic [LANES-1:0][CLS_W-1:0] wr_cls,
  input  logic [LANES-1:0][TAG_W-1:0] wr_src_a,
  input  logic [LANES-1:0]            wr_rdy_a,
  input  logic [LANES-1:0][TAG_W-1:0] wr_src_b,
  input  logic [LANES-1:0]            wr_rdy_b,
  input  logic [LANES-1:0][TAG_W-1:0] wr_dst,
  input  logic [LANES-1:0]            wb_vld,
  input  logic [LANES-1:0][TAG_W-1:0] wb_tag,
  output logic                        full,
  output logic                        add_vld,
  output logic [TAG_W-1:0]            add_dst,
  output logic                        mul_vld,
  output logic [TAG_W-1:0]            mul_dst,
  output logic                        st_vld,
  output logic [TAG_W-1:0]            st_dst
);
  // Window state
  logic [DEPTH-1:0]            ent_vld, ent_rdy_a, ent_rdy_b;
  logic [TAG_W-1:0]            ent_src_a [DEPTH];
  logic [TAG_W-1:0]            ent_src_b [DEPTH];
  logic [TAG_W-1:0]            ent_dst   [DEPTH];
  logic [CLS_W-1:0]            ent_cls   [DEPTH];
  logic [DEPTH-1:0][DEPTH-1:0] ent_blk;

  // Per-cycle decisions
  logic [DEPTH-1:0]            wake_a, wake_b, elig;
  logic [DEPTH-1:0]            c_add, c_mulbase, c_mul, c_st;
  logic [DEPTH-1:0]            pick_add, pick_mul, pick_st, new_mask;
  logic [LANES-1:0][DEPTH-1:0] slot, lower_new;
  logic [LANES-1:0]            we, hit_a_in, hit_b_in;
  logic [TAG_W-1:0]            add_d, mul_d, st_d;

  function automatic logic tag_hit(input logic [TAG_W-1:0] t,
                                   input logic [LANES-1:0] v,
                                   input logic [LANES-1:0][TAG_W-1:0] tg);
    logic h;
    h = 1'b0;
    for (int k = 0; k < LANES; k++)
      if (v[k] && tg[k] == t) h = 1'b1;
    return h;
  endfunction

  // Wakeup and per-pipe candidate decode
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      wake_a[i]    = tag_hit(ent_src_a[i], wb_vld, wb_tag);
      wake_b[i]    = tag_hit(ent_src_b[i], wb_vld, wb_tag);
      elig[i]      = ent_vld[i] & ent_rdy_a[i] & ent_rdy_b[i];
      c_add[i]     = elig[i] & (ent_cls[i] == OC_FADD || ent_cls[i] == OC_PADD);
      c_mulbase[i] = elig[i] & (ent_cls[i] == OC_FMUL || ent_cls[i] == OC_PMUL ||
                                ent_cls[i] == OC_PADD);
      c_st[i]      = elig[i] & (ent_cls[i] == OC_STORE);
    end
    for (int l = 0; l < LANES; l++) begin
      hit_a_in[l] = tag_hit(wr_src_a[l], wb_vld, wb_tag);
      hit_b_in[l] = tag_hit(wr_src_b[l], wb_vld, wb_tag);
    end
  end

  // Add pipe picks first; the multiply pipe skips the add winner.
  assign c_mul = c_mulbase & ~pick_add;

  fp_issue_pick #(.DEPTH(DEPTH)) u_pick_add (.cand(c_add), .blk(ent_blk), .sel(pick_add));
  fp_issue_pick #(.DEPTH(DEPTH)) u_pick_mul (.cand(c_mul), .blk(ent_blk), .sel(pick_mul));
  fp_issue_pick #(.DEPTH(DEPTH)) u_pick_st  (.cand(c_st),  .blk(ent_blk), .sel(pick_st));

  fp_issue_alloc #(.DEPTH(DEPTH), .LANES(LANES)) u_alloc (
    .free_mask(~ent_vld),
    .req      (wr_vld),
    .slot     (slot),
    .full     (full)
  );

  assign we = wr_vld & {LANES{~full}};

  // Slots taken by lower write lanes this cycle are older than this lane.
  always_comb begin
    logic [DEPTH-1:0] acc;
    acc = '0;
    for (int l = 0; l < LANES; l++) begin
      lower_new[l] = acc;
      if (we[l]) acc = acc | slot[l];
    end
    new_mask = acc;
  end

  // Destination tag of each winner
  always_comb begin
    add_d = '0;
    mul_d = '0;
    st_d  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (pick_add[i]) add_d = add_d | ent_dst[i];
      if (pick_mul[i]) mul_d = mul_d | ent_dst[i];
      if (pick_st[i])  st_d  = st_d  | ent_dst[i];
    end
  end

  // Payload and age matrix: no reset, rewritten on every allocation
  always_ff @(posedge clk) begin
    for (int x = 0; x < DEPTH; x++) begin
      ent_blk[x] <= ent_blk[x] & ~new_mask;
      if (wake_a[x]) ent_rdy_a[x] <= 1'b1;
      if (wake_b[x]) ent_rdy_b[x] <= 1'b1;
    end
    for (int l = 0; l < LANES; l++) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (we[l] && slot[l][i]) begin
          ent_src_a[i] <= wr_src_a[l];
          ent_src_b[i] <= wr_src_b[l];
          ent_dst[i]   <= wr_dst[l];
          ent_cls[i]   <= wr_cls[l];
          ent_rdy_a[i] <= wr_rdy_a[l] | hit_a_in[l];
          ent_rdy_b[i] <= wr_rdy_b[l] | hit_b_in[l];
          ent_blk[i]   <= ent_vld | lower_new[l];
        end
      end
    end
  end

  // Occupancy and registered issue outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      ent_vld <= '0;
      add_vld <= 1'b0;
      mul_vld <= 1'b0;
      st_vld  <= 1'b0;
      add_dst <= '0;
      mul_dst <= '0;
      st_dst  <= '0;
    end else begin
      ent_vld <= (ent_vld & ~(pick_add | pick_mul | pick_st)) | new_mask;
      add_vld <= |pick_add;
      mul_vld <= |pick_mul;
      st_vld  <= |pick_st;
      add_dst <= add_d;
      mul_dst <= mul_d;
      st_dst  <= st_d;
    end
  end
endmodule

// File: rtl/fp_issue_sched_chk.sv
module fp_issue_sched_chk #(
  parameter int DEPTH = 36
) (
  input logic             clk,
  input logic             rst,
  input logic             full,
  input logic [DEPTH-1:0] ent_vld,
  input logic [DEPTH-1:0] ent_rdy_a,
  input logic [DEPTH-1:0] ent_rdy_b,
  input logic [DEPTH-1:0] pick_add,
  input logic [DEPTH-1:0] pick_mul,
  input logic [DEPTH-1:0] pick_st,
  input logic             add_vld,
  input logic             mul_vld,
  input logic             st_vld
);
  p_one_per_pipe_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pick_add) && $onehot0(pick_mul) && $onehot0(pick_st));

  p_pipes_disjoint_r7: assert property (@(posedge clk) disable iff (rst)
    ((pick_add & pick_mul) == '0) && ((pick_add & pick_st) == '0) &&
    ((pick_mul & pick_st) == '0));

  p_issue_ready_r4: assert property (@(posedge clk) disable iff (rst)
    ((pick_add | pick_mul | pick_st) & ~(ent_vld & ent_rdy_a & ent_rdy_b)) == '0);

  p_full_no_grow_r3: assert property (@(posedge clk) disable iff (rst)
    full |=> $countones(ent_vld) <= $past($countones(ent_vld)));

  p_freed_r9: assert property (@(posedge clk) disable iff (rst)
    ((pick_add | pick_mul | pick_st) != '0) |=>
      ((ent_vld & $past(pick_add | pick_mul | pick_st)) == '0));

  p_add_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    add_vld |-> $past(pick_add != '0));

  p_mul_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    mul_vld |-> $past(pick_mul != '0));

  p_st_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    st_vld |-> $past(pick_st != '0));
endmodule

bind fp_issue_sched fp_issue_sched_chk #(.DEPTH(DEPTH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .full     (full),
  .ent_vld  (ent_vld),
  .ent_rdy_a(ent_rdy_a),
  .ent_rdy_b(ent_rdy_b),
  .pick_add (pick_add),
  .pick_mul (pick_mul),
  .pick_st  (pick_st),
  .add_vld  (add_vld),
  .mul_vld  (mul_vld),
  .st_vld   (st_vld)
);

// File: tb/fp_issue_sched_bench.sv
module fp_issue_sched_bench;
  localparam int D = 36;
  localparam int L = 3;
  localparam int T = 6;

  logic                clk = 1'b0;
  logic                rst;
  logic [L-1:0]        wr_vld, wr_rdy_a, wr_rdy_b, wb_vld;
  logic [L-1:0][2:0]   wr_cls;
  logic [L-1:0][T-1:0] wr_src_a, wr_src_b, wr_dst, wb_tag;
  logic                full, add_vld, mul_vld, st_vld;
  logic [T-1:0]        add_dst, mul_dst, st_dst;

  fp_issue_sched #(.DEPTH(D), .LANES(L), .TAG_W(T)) u_fp_issue_sched (
    .clk(clk), .rst(rst),
    .wr_vld(wr_vld), .wr_cls(wr_cls),
    .wr_src_a(wr_src_a), .wr_rdy_a(wr_rdy_a),
    .wr_src_b(wr_src_b), .wr_rdy_b(wr_rdy_b),
    .wr_dst(wr_dst), .wb_vld(wb_vld), .wb_tag(wb_tag),
    .full(full),
    .add_vld(add_vld), .add_dst(add_dst),
    .mul_vld(mul_vld), .mul_dst(mul_dst),
    .st_vld(st_vld), .st_dst(st_dst)
  );

  always #2 clk = ~clk;  // 250 MHz

  // Reference model of the window
  bit          m_vld [D];
  bit          m_ra  [D];
  bit          m_rb  [D];
  int          m_sa  [D];
  int          m_sb  [D];
  int          m_cls [D];
  int          m_dst [D];
  int          m_seq [D];
  int          seq_ctr = 0;
  int          dst_ctr = 0;
  int          n_chk = 0;
  int          n_err = 0;
  string       cur_req = "R1";
  int unsigned seed_sink;

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", cur_req, what, act, exp);
    end
  endtask

  task automatic clr_in();
    wr_vld = '0; wr_rdy_a = '0; wr_rdy_b = '0; wb_vld = '0;
    wr_cls = '0; wr_src_a = '0; wr_src_b = '0; wr_dst = '0; wb_tag = '0;
  endtask

  task automatic put(input int l, input int cls, input int sa, input bit ra,
                     input int sb, input bit rb);
    wr_vld[l]   = 1'b1;
    wr_cls[l]   = 3'(cls);
    wr_src_a[l] = T'(sa);
    wr_rdy_a[l] = ra;
    wr_src_b[l] = T'(sb);
    wr_rdy_b[l] = rb;
    wr_dst[l]   = T'(dst_ctr);
    dst_ctr++;
  endtask

  task automatic bcast(input int l, input int tag);
    wb_vld[l] = 1'b1;
    wb_tag[l] = T'(tag);
  endtask

  function automatic bit wb_hit(input int t);
    for (int k = 0; k < L; k++)
      if (wb_vld[k] && int'(wb_tag[k]) == t) return 1'b1;
    return 1'b0;
  endfunction

  function automatic int oldest(input int c0, input int c1, input int c2, input int skip);
    int w;
    w = -1;
    for (int i = 0; i < D; i++)
      if (m_vld[i] && m_ra[i] && m_rb[i] && i != skip &&
          (m_cls[i] == c0 || m_cls[i] == c1 || m_cls[i] == c2))
        if (w < 0 || m_seq[i] < m_seq[w]) w = i;
    return w;
  endfunction

  // Called at a falling edge with inputs already driven; ends at the next one.
  task automatic step();
    int nfree, nreq, ea, em, es, xa, xm, xs;
    bit ef;
    #1;
    nfree = 0;
    for (int i = 0; i < D; i++) if (!m_vld[i]) nfree++;
    nreq = $countones(wr_vld);
    ef = (nfree < nreq);
    chk(full == ef, "full", int'(full), int'(ef));
    ea = oldest(0, 3, 3, -1);
    em = oldest(1, 3, 4, ea);
    es = oldest(2, 2, 2, -1);
    xa = (ea >= 0) ? m_dst[ea] : 0;
    xm = (em >= 0) ? m_dst[em] : 0;
    xs = (es >= 0) ? m_dst[es] : 0;
    @(posedge clk);
    for (int i = 0; i < D; i++) begin
      if (m_vld[i] && wb_hit(m_sa[i])) m_ra[i] = 1'b1;
      if (m_vld[i] && wb_hit(m_sb[i])) m_rb[i] = 1'b1;
    end
    if (!ef) begin
      for (int l = 0; l < L; l++) begin
        if (wr_vld[l]) begin
          for (int i = 0; i < D; i++) begin
            if (!m_vld[i]) begin
              m_vld[i] = 1'b1;
              m_sa[i]  = int'(wr_src_a[l]);
              m_sb[i]  = int'(wr_src_b[l]);
              m_ra[i]  = wr_rdy_a[l] | wb_hit(m_sa[i]);
              m_rb[i]  = wr_rdy_b[l] | wb_hit(m_sb[i]);
              m_cls[i] = int'(wr_cls[l]);
              m_dst[i] = int'(wr_dst[l]);
              m_seq[i] = seq_ctr;
              seq_ctr++;
              break;
            end
          end
        end
      end
    end
    if (ea >= 0) m_vld[ea] = 1'b0;
    if (em >= 0) m_vld[em] = 1'b0;
    if (es >= 0) m_vld[es] = 1'b0;
    @(negedge clk);
    chk(add_vld == (ea >= 0), "add_vld", int'(add_vld), int'(ea >= 0));
    chk(mul_vld == (em >= 0), "mul_vld", int'(mul_vld), int'(em >= 0));
    chk(st_vld  == (es >= 0), "st_vld",  int'(st_vld),  int'(es >= 0));
    if (ea >= 0) chk(int'(add_dst) == xa, "add_dst", int'(add_dst), xa);
    if (em >= 0) chk(int'(mul_dst) == xm, "mul_dst", int'(mul_dst), xm);
    if (es >= 0) chk(int'(st_dst)  == xs, "st_dst",  int'(st_dst),  xs);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      clr_in();
      step();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    seed_sink = $urandom(32'd4242);
    for (int i = 0; i < D; i++) m_vld[i] = 1'b0;
    clr_in();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    cur_req = "R1";
    chk(full == 1'b0, "reset full", int'(full), 0);
    chk(add_vld == 1'b0, "reset add_vld", int'(add_vld), 0);
    chk(mul_vld == 1'b0, "reset mul_vld", int'(mul_vld), 0);
    chk(st_vld == 1'b0, "reset st_vld", int'(st_vld), 0);
    @(negedge clk);

    // R6 / R10: one of each fixed class, written ready
    cur_req = "R6";
    clr_in(); put(0, 0, 0, 1, 0, 1); put(1, 1, 0, 1, 0, 1); put(2, 2, 0, 1, 0, 1);
    step();
    cur_req = "R10";
    idle(2);
    cur_req = "R6";
    clr_in(); put(0, 4, 0, 1, 0, 1); put(1, 3, 0, 1, 0, 1);
    step();
    idle(2);

    // R8: two packed adds and a packed multiply in one group
    cur_req = "R8";
    clr_in(); put(0, 3, 0, 1, 0, 1); put(1, 3, 0, 1, 0, 1); put(2, 4, 0, 1, 0, 1);
    step();
    idle(3);

    // R7: same-class bursts across two cycles
    cur_req = "R7";
    clr_in(); put(0, 0, 0, 1, 0, 1); put(1, 0, 0, 1, 0, 1); put(2, 0, 0, 1, 0, 1);
    step();
    clr_in(); put(0, 0, 0, 1, 0, 1); put(1, 1, 0, 1, 0, 1);
    step();
    idle(6);

    // R4 / R5: blocked source, later wake and same-cycle wake
    cur_req = "R4";
    clr_in(); put(0, 0, 5, 0, 0, 1); put(1, 2, 0, 1, 9, 0);
    step();
    idle(3);
    cur_req = "R5";
    clr_in(); bcast(0, 5); bcast(2, 9);
    step();
    idle(2);
    clr_in(); put(0, 1, 7, 0, 8, 0); bcast(1, 7); bcast(2, 8);
    step();
    idle(2);

    // R2 / R3 / R9: fill to capacity, overflow, reuse of a freed slot
    cur_req = "R2";
    for (int g = 0; g < 11; g++) begin
      clr_in(); put(0, 0, 63, 0, 0, 1); put(1, 1, 63, 0, 0, 1); put(2, 3, 63, 0, 0, 1);
      step();
    end
    clr_in(); put(0, 0, 63, 0, 0, 1); put(1, 1, 63, 0, 0, 1); put(2, 2, 0, 1, 0, 1);
    step();
    cur_req = "R3";
    clr_in(); put(0, 2, 0, 1, 0, 1);
    step();
    clr_in(); put(0, 2, 0, 1, 0, 1); put(1, 2, 0, 1, 0, 1);
    step();
    cur_req = "R9";
    clr_in(); put(0, 2, 0, 1, 0, 1);
    step();
    idle(2);
    clr_in(); bcast(0, 63);
    step();
    idle(14);

    // Random mix against the model
    cur_req = "R7";
    for (int c = 0; c < 500; c++) begin
      clr_in();
      for (int l = 0; l < L; l++) begin
        if ($urandom_range(1, 0) == 1)
          put(l, int'($urandom_range(4, 0)), int'($urandom_range(15, 0)),
              $urandom_range(9, 0) < 7, int'($urandom_range(15, 0)),
              $urandom_range(9, 0) < 7);
        if ($urandom_range(2, 0) == 0) bcast(l, int'($urandom_range(15, 0)));
      end
      step();
    end
    cur_req = "R8";
    for (int r = 0; r < 3; r++) begin
      for (int t = 0; t < 16; t += 3) begin
        clr_in();
        for (int l = 0; l < L; l++) if (t + l < 16) bcast(l, t + l);
        step();
      end
    end
    idle(20);

    summary();
    $finish;
  end
endmodule